// File: doc/BRIEF.md
# Packet Wake Filter for a Sleeping Tag Controller

This block sits between the receive path of a radio tag and its main controller. While a command packet is still being buffered, the receive path hands this block the header fields it has already pulled out of the packet. These are the opcode, a broadcast or point-to-point flag, the packet's owner, group and tag identifiers, and a flag that says whether an owner identifier is carried. The block compares them with the identifiers stored in the tag and decides whether the controller must wake up. Packets meant for other tags are dropped, and the controller stays asleep.

Two rule sets are supported and picked by a mode input. The first (mode 0) bins tags by an owner identifier, and a tag without a stored owner identifier answers every broadcast. The second (mode 1) bins tags by a group identifier. In mode 1 a stored group of zero matches any group, and the broadcast rules depend on the opcode. The decision is taken and held when the fields-valid strobe arrives. It is then released as a single-cycle wake pulse, or as a drop pulse, in the cycle after end-of-packet. The stored identifiers are loaded through three simple write ports.

Top module: `pkt_wake_filter`

## Requirements
- R1: In mode 0, a broadcast packet (bcast_i=1) is accepted whenever no owner identifier is stored, whatever the packet carries.
- R2: In mode 0, when an owner identifier is stored, a broadcast is accepted only if pkt_has_owner_i=1 and pkt_owner_i equals the stored owner. A broadcast without an owner identifier is rejected.
- R3: In mode 0, a point-to-point packet (bcast_i=0) needs pkt_tag_i equal to the stored tag. If the tag holds an owner identifier and the packet carries one, the two must also be equal.
- R4: In mode 1, broadcast opcodes 16 and 35 (decimal) are always accepted. Broadcast opcode 30 is accepted only when pkt_group_i equals the stored group or the stored group is zero.
- R5: In mode 1, a broadcast with any opcode other than 16, 30 and 35 is rejected.
- R6: In mode 1, a point-to-point packet is accepted only on a tag match. Owner fields have no effect.
- R7: An accepted packet gives wake_o=1 for exactly the one cycle after the cycle in which eop_i=1 is sampled. This holds whether fields_valid_i came in that same cycle or any number of cycles earlier.
- R8: A rejected packet gives drop_o=1 for the one cycle after eop_i and never raises wake_o. An eop_i that arrives while no decision is held (no fields_valid_i before or with it) also gives drop_o. wake_o and drop_o are never high together.
- R9: Reset clears the owner-present flag, the stored group and tag (to TAG_RST, default 0) and both outputs. An owner write sets the flag for good and loads the value. Writes take effect from the next cycle.
- R10: The decision uses the fields, mode and stored identifiers of the fields_valid_i cycle. Later changes to those inputs, and further fields_valid_i strobes, have no effect until end-of-packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Rule set: 0 owner-binned, 1 group-binned |
| opcode_i | input | OPC_W | Packet opcode |
| bcast_i | input | 1 | 1 broadcast, 0 point-to-point |
| pkt_has_owner_i | input | 1 | Packet carries an owner identifier |
| pkt_owner_i | input | OWN_W | Packet owner identifier |
| pkt_group_i | input | GRP_W | Packet group identifier |
| pkt_tag_i | input | TAG_W | Packet destination tag identifier |
| fields_valid_i | input | 1 | Header fields valid this cycle |
| eop_i | input | 1 | Packet fully buffered |
| owner_wr_i | input | 1 | Load stored owner identifier |
| owner_wdata_i | input | OWN_W | Owner identifier to store |
| group_wr_i | input | 1 | Load stored group identifier |
| group_wdata_i | input | GRP_W | Group identifier to store |
| tag_wr_i | input | 1 | Load stored tag identifier |
| tag_wdata_i | input | TAG_W | Tag identifier to store |
| wake_o | output | 1 | One-cycle wake pulse for the controller |
| drop_o | output | 1 | One-cycle drop pulse for the buffer |

## Verification
The assertions check several things on every cycle. Wake and drop are never high together, and each pulse follows an end-of-packet. The owner-present flag never falls once set. Mode 1 never accepts a reserved broadcast opcode or a tag mismatch. Mode 0 never accepts an owner-bound broadcast that has no owner. Only the bench scenarios can show the acceptance cases themselves: the wildcard behaviour of an empty owner and a zero group, decisions held across long gaps while the inputs change, write-before-use ordering, and back-to-back packets. The bench checks these against its own rule model.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

    typedef enum logic {
        STD_OWNER_BINS = 1'b0,
        STD_GROUP_BINS = 1'b1
    } std_mode_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_HELD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic accept;
        logic tag_hit;
        logic owner_hit;
        logic group_hit;
    } verdict_t;

    localparam int OPC_ANY_LO  = 16;
    localparam int OPC_GROUPED = 30;
    localparam int OPC_ANY_HI  = 35;

    function automatic logic owner_rule_bcast(input logic stored_valid,
                                              input logic pkt_has,
                                              input logic owner_eq);
        return !stored_valid || (pkt_has && owner_eq);
    endfunction

    function automatic logic owner_rule_p2p(input logic stored_valid,
                                            input logic pkt_has,
                                            input logic owner_eq,
                                            input logic tag_eq);
        return tag_eq && (!(stored_valid && pkt_has) || owner_eq);
    endfunction

endpackage

// File: rtl/pwf_id_store.sv
module pwf_id_store #(
    parameter int              OWN_W   = 16,
    parameter int              GRP_W   = 8,
    parameter int              TAG_W   = 32,
    parameter logic [TAG_W-1:0] TAG_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             owner_wr,
    input  logic [OWN_W-1:0] owner_wdata,
    input  logic             group_wr,
    input  logic [GRP_W-1:0] group_wdata,
    input  logic             tag_wr,
    input  logic [TAG_W-1:0] tag_wdata,
    output logic             owner_set,
    output logic [OWN_W-1:0] owner_q,
    output logic [GRP_W-1:0] group_q,
    output logic [TAG_W-1:0] tag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_set <= 1'b0;
            owner_q   <= '0;
        end else if (owner_wr) begin
            owner_set <= 1'b1;
            owner_q   <= owner_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            group_q <= '0;
        end else if (group_wr) begin
            group_q <= group_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= TAG_RST;
        end else if (tag_wr) begin
            tag_q <= tag_wdata;
        end
    end

    // R9: the owner-present flag has no path back to zero outside reset
    assert_owner_flag_sticky_R9: assert property (
        @(posedge clk) disable iff (rst) owner_set |=> owner_set)
        else $error("owner flag cleared without reset");

    // R9: an owner write is visible from the next cycle
    assert_owner_write_lands_R9: assert property (
        @(posedge clk) disable iff (rst)
        owner_wr |=> (owner_set && owner_q == $past(owner_wdata)))
        else $error("owner write not stored");

endmodule

// File: rtl/pwf_rule_eval.sv
module pwf_rule_eval
    import pwf_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int OWN_W = 16,
    parameter int GRP_W = 8,
    parameter int TAG_W = 32
) (
    input  std_mode_e        mode,
    input  logic             bcast,
    input  logic [OPC_W-1:0] opcode,
    input  logic             pkt_has_owner,
    input  logic [OWN_W-1:0] pkt_owner,
    input  logic [GRP_W-1:0] pkt_group,
    input  logic [TAG_W-1:0] pkt_tag,
    input  logic             st_owner_set,
    input  logic [OWN_W-1:0] st_owner,
    input  logic [GRP_W-1:0] st_group,
    input  logic [TAG_W-1:0] st_tag,
    output verdict_t         verdict
);

    localparam logic [OPC_W-1:0] OP_LO  = OPC_W'(OPC_ANY_LO);
    localparam logic [OPC_W-1:0] OP_GRP = OPC_W'(OPC_GROUPED);
    localparam logic [OPC_W-1:0] OP_HI  = OPC_W'(OPC_ANY_HI);

    logic tag_eq;
    logic owner_eq;
    logic group_ok;
    logic own_bc_ok;
    logic own_pp_ok;
    logic grp_bc_ok;

    always_comb begin
        tag_eq   = (pkt_tag == st_tag);
        owner_eq = (pkt_owner == st_owner);
        group_ok = (st_group == '0) || (pkt_group == st_group);

        own_bc_ok = owner_rule_bcast(st_owner_set, pkt_has_owner, owner_eq);
        own_pp_ok = owner_rule_p2p(st_owner_set, pkt_has_owner, owner_eq, tag_eq);

        unique case (opcode)
            OP_LO, OP_HI: grp_bc_ok = 1'b1;
            OP_GRP:       grp_bc_ok = group_ok;
            default:      grp_bc_ok = 1'b0;
        endcase

        verdict.tag_hit   = tag_eq;
        verdict.owner_hit = owner_eq;
        verdict.group_hit = group_ok;
        if (mode == STD_OWNER_BINS) begin
            verdict.accept = bcast ? own_bc_ok : own_pp_ok;
        end else begin
            verdict.accept = bcast ? grp_bc_ok : tag_eq;
        end
    end

endmodule

// File: rtl/pwf_wake_seq.sv
module pwf_wake_seq
    import pwf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fields_valid,
    input  logic eop,
    input  logic accept_now,
    output logic wake,
    output logic drop
);

    seq_state_e state;
    logic       held_accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            held_accept <= 1'b0;
            wake        <= 1'b0;
            drop        <= 1'b0;
        end else begin
            wake <= 1'b0;
            drop <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (fields_valid && eop) begin
                        wake <= accept_now;
                        drop <= !accept_now;
                    end else if (fields_valid) begin
                        held_accept <= accept_now;
                        state       <= SQ_HELD;
                    end else if (eop) begin
                        drop <= 1'b1;
                    end
                end
                SQ_HELD: begin
                    if (eop) begin
                        wake  <= held_accept;
                        drop  <= !held_accept;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R8: the two outcomes exclude each other
    assert_outcome_exclusive_R8: assert property (
        @(posedge clk) disable iff (rst) $onehot0({wake, drop}))
        else $error("wake and drop together");

    // R7: a wake only ever follows a sampled end-of-packet
    assert_wake_after_eop_R7: assert property (
        @(posedge clk) disable iff (rst) wake |-> $past(eop))
        else $error("wake without end-of-packet");

    // R8: a drop only ever follows a sampled end-of-packet
    assert_drop_after_eop_R8: assert property (
        @(posedge clk) disable iff (rst) drop |-> $past(eop))
        else $error("drop without end-of-packet");

    // R7: end-of-packet always produces exactly one outcome next cycle
    assert_eop_resolves_R7: assert property (
        @(posedge clk) disable iff (rst) eop |=> (wake || drop))
        else $error("end-of-packet produced no outcome");

endmodule

// File: rtl/pkt_wake_filter.sv
module pkt_wake_filter
    import pwf_pkg::*;
#(
    parameter int               OPC_W   = 8,
    parameter int               OWN_W   = 16,
    parameter int               GRP_W   = 8,
    parameter int               TAG_W   = 32,
    parameter logic [TAG_W-1:0] TAG_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             bcast_i,
    input  logic             pkt_has_owner_i,
    input  logic [OWN_W-1:0] pkt_owner_i,
    input  logic [GRP_W-1:0] pkt_group_i,
    input  logic [TAG_W-1:0] pkt_tag_i,
    input  logic             fields_valid_i,
    input  logic             eop_i,
    input  logic             owner_wr_i,
    input  logic [OWN_W-1:0] owner_wdata_i,
    input  logic             group_wr_i,
    input  logic [GRP_W-1:0] group_wdata_i,
    input  logic             tag_wr_i,
    input  logic [TAG_W-1:0] tag_wdata_i,
    output logic             wake_o,
    output logic             drop_o
);

    logic             st_owner_set;
    logic [OWN_W-1:0] st_owner;
    logic [GRP_W-1:0] st_group;
    logic [TAG_W-1:0] st_tag;
    verdict_t         verdict;
    std_mode_e        mode;

    assign mode = std_mode_e'(mode_i);

    pwf_id_store #(
        .OWN_W  (OWN_W),
        .GRP_W  (GRP_W),
        .TAG_W  (TAG_W),
        .TAG_RST(TAG_RST)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .owner_wr   (owner_wr_i),
        .owner_wdata(owner_wdata_i),
        .group_wr   (group_wr_i),
        .group_wdata(group_wdata_i),
        .tag_wr     (tag_wr_i),
        .tag_wdata  (tag_wdata_i),
        .owner_set  (st_owner_set),
        .owner_q    (st_owner),
        .group_q    (st_group),
        .tag_q      (st_tag)
    );

    pwf_rule_eval #(
        .OPC_W(OPC_W),
        .OWN_W(OWN_W),
        .GRP_W(GRP_W),
        .TAG_W(TAG_W)
    ) u_eval (
        .mode         (mode),
        .bcast        (bcast_i),
        .opcode       (opcode_i),
        .pkt_has_owner(pkt_has_owner_i),
        .pkt_owner    (pkt_owner_i),
        .pkt_group    (pkt_group_i),
        .pkt_tag      (pkt_tag_i),
        .st_owner_set (st_owner_set),
        .st_owner     (st_owner),
        .st_group     (st_group),
        .st_tag       (st_tag),
        .verdict      (verdict)
    );

    pwf_wake_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .fields_valid(fields_valid_i),
        .eop         (eop_i),
        .accept_now  (verdict.accept),
        .wake        (wake_o),
        .drop        (drop_o)
    );

    // R5: reserved broadcast opcodes never pass the group-binned rules
    assert_reserved_opcode_rejected_R5: assert property (
        @(posedge clk) disable iff (rst)
        (mode_i && bcast_i && opcode_i != OPC_W'(OPC_ANY_LO) &&
         opcode_i != OPC_W'(OPC_GROUPED) && opcode_i != OPC_W'(OPC_ANY_HI))
        |-> !verdict.accept)
        else $error("reserved broadcast opcode accepted");

    // R6: group-binned point-to-point needs the stored tag
    assert_p2p_needs_tag_R6: assert property (
        @(posedge clk) disable iff (rst)
        (mode_i && !bcast_i && pkt_tag_i != st_tag) |-> !verdict.accept)
        else $error("point-to-point accepted on tag mismatch");

    // R2: owner-bound broadcast without an owner field is refused
    assert_owner_bound_bcast_R2: assert property (
        @(posedge clk) disable iff (rst)
        (!mode_i && bcast_i && st_owner_set && !pkt_has_owner_i) |-> !verdict.accept)
        else $error("owner-bound broadcast accepted without owner");

endmodule

// File: tb/pkt_wake_filter_test.sv
module pkt_wake_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic        bcast_i = 1'b0;
    logic        pkt_has_owner_i = 1'b0;
    logic [15:0] pkt_owner_i = '0;
    logic [7:0]  pkt_group_i = '0;
    logic [31:0] pkt_tag_i = '0;
    logic        fields_valid_i = 1'b0;
    logic        eop_i = 1'b0;
    logic        owner_wr_i = 1'b0;
    logic [15:0] owner_wdata_i = '0;
    logic        group_wr_i = 1'b0;
    logic [7:0]  group_wdata_i = '0;
    logic        tag_wr_i = 1'b0;
    logic [31:0] tag_wdata_i = '0;
    logic        wake_o;
    logic        drop_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur = "R9";

    always #2 clk = ~clk;

    pkt_wake_filter uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .opcode_i(opcode_i),
        .bcast_i(bcast_i), .pkt_has_owner_i(pkt_has_owner_i),
        .pkt_owner_i(pkt_owner_i), .pkt_group_i(pkt_group_i),
        .pkt_tag_i(pkt_tag_i), .fields_valid_i(fields_valid_i),
        .eop_i(eop_i), .owner_wr_i(owner_wr_i), .owner_wdata_i(owner_wdata_i),
        .group_wr_i(group_wr_i), .group_wdata_i(group_wdata_i),
        .tag_wr_i(tag_wr_i), .tag_wdata_i(tag_wdata_i),
        .wake_o(wake_o), .drop_o(drop_o)
    );

    // ---------------- reference model ----------------
    bit          m_own_v;
    logic [15:0] m_own;
    logic [7:0]  m_grp;
    logic [31:0] m_tag;
    bit          m_busy;
    bit          m_acc;
    bit          e_wake;
    bit          e_drop;

    function automatic bit ref_accept();
        if (mode_i == 1'b0) begin
            if (bcast_i) begin
                if (!m_own_v) return 1;
                return pkt_has_owner_i && (pkt_owner_i == m_own);
            end
            if (pkt_tag_i != m_tag) return 0;
            if (m_own_v && pkt_has_owner_i) return pkt_owner_i == m_own;
            return 1;
        end
        if (!bcast_i) return pkt_tag_i == m_tag;
        if (opcode_i == 8'd16 || opcode_i == 8'd35) return 1;
        if (opcode_i == 8'd30) return (m_grp == 0) || (m_grp == pkt_group_i);
        return 0;
    endfunction

    always @(posedge clk) begin
        bit a;
        if (rst) begin
            m_own_v = 0; m_own = '0; m_grp = '0; m_tag = '0;
            m_busy = 0; m_acc = 0; e_wake = 0; e_drop = 0;
        end else begin
            a = ref_accept();
            e_wake = 0;
            e_drop = 0;
            if (m_busy) begin
                if (eop_i) begin
                    e_wake = m_acc; e_drop = !m_acc; m_busy = 0;
                end
            end else if (fields_valid_i) begin
                if (eop_i) begin
                    e_wake = a; e_drop = !a;
                end else begin
                    m_busy = 1; m_acc = a;
                end
            end else if (eop_i) begin
                e_drop = 1;
            end
            if (owner_wr_i) begin m_own_v = 1; m_own = owner_wdata_i; end
            if (group_wr_i) m_grp = group_wdata_i;
            if (tag_wr_i)   m_tag = tag_wdata_i;
        end
    end

    task automatic check(input string t, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: {wake,drop} actual %b expected %b at %0t", t, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) check({cur, " (model)"}, {wake_o, drop_o}, {e_wake, e_drop});
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_owner(input logic [15:0] v);
        @(negedge clk); owner_wr_i = 1; owner_wdata_i = v;
        @(negedge clk); owner_wr_i = 0;
    endtask

    task automatic wr_group(input logic [7:0] v);
        @(negedge clk); group_wr_i = 1; group_wdata_i = v;
        @(negedge clk); group_wr_i = 0;
    endtask

    task automatic wr_tag(input logic [31:0] v);
        @(negedge clk); tag_wr_i = 1; tag_wdata_i = v;
        @(negedge clk); tag_wr_i = 0;
    endtask

    task automatic pkt(input string t, input logic m, input logic b, input logic [7:0] op,
                       input logic ho, input logic [15:0] ow, input logic [7:0] gp,
                       input logic [31:0] tg, input int gap, input bit scr, input bit exp);
        @(negedge clk);
        cur = t;
        mode_i = m; bcast_i = b; opcode_i = op; pkt_has_owner_i = ho;
        pkt_owner_i = ow; pkt_group_i = gp; pkt_tag_i = tg;
        fields_valid_i = 1; eop_i = (gap == 0);
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            fields_valid_i = scr && (i == 1);
            eop_i = (i == gap);
            if (scr) begin
                mode_i = ~m; bcast_i = ~b; opcode_i = op ^ 8'h3C;
                pkt_has_owner_i = ~ho; pkt_owner_i = ~ow;
                pkt_group_i = ~gp; pkt_tag_i = ~tg;
            end
        end
        @(negedge clk);
        fields_valid_i = 0; eop_i = 0;
        check(t, {wake_o, drop_o}, {exp, ~exp});
    endtask

    localparam logic [31:0] MY_TAG = 32'hA5A5_0001;
    localparam logic [15:0] MY_OWN = 16'h1234;

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset outputs", {wake_o, drop_o}, 2'b00);
        rst = 0;
        @(negedge clk);
        check("R9 idle after reset", {wake_o, drop_o}, 2'b00);

        // R1: no owner stored, broadcasts always pass (tag still reset value)
        pkt("R1 bcast owner field", 0, 1, 8'h01, 1, 16'h7777, 8'h00, 32'h0, 0, 0, 1);
        pkt("R1 bcast no owner field", 0, 1, 8'h01, 0, 16'h0000, 8'h00, 32'h0, 0, 0, 1);

        wr_tag(MY_TAG);
        wr_owner(MY_OWN);
        cur = "R9";

        // R2
        pkt("R2 bcast owner match", 0, 1, 8'h02, 1, MY_OWN, 8'h00, 32'h0, 0, 0, 1);
        pkt("R2 bcast owner mismatch", 0, 1, 8'h02, 1, 16'h1235, 8'h00, 32'h0, 0, 0, 0);
        pkt("R2 bcast owner missing", 0, 1, 8'h02, 0, MY_OWN, 8'h00, 32'h0, 0, 0, 0);

        // R3
        pkt("R3 p2p tag+owner match", 0, 0, 8'h05, 1, MY_OWN, 8'h00, MY_TAG, 0, 0, 1);
        pkt("R3 p2p owner mismatch", 0, 0, 8'h05, 1, 16'h4321, 8'h00, MY_TAG, 0, 0, 0);
        pkt("R3 p2p no owner in packet", 0, 0, 8'h05, 0, 16'h4321, 8'h00, MY_TAG, 0, 0, 1);
        pkt("R3 p2p tag mismatch", 0, 0, 8'h05, 1, MY_OWN, 8'h00, MY_TAG ^ 32'h1, 0, 0, 0);

        // R4
        pkt("R4 opcode 16", 1, 1, 8'd16, 0, 16'h0, 8'h99, 32'h0, 0, 0, 1);
        pkt("R4 opcode 35", 1, 1, 8'd35, 0, 16'h0, 8'h99, 32'h0, 0, 0, 1);
        pkt("R4 opcode 30 zero group wildcard", 1, 1, 8'd30, 0, 16'h0, 8'h07, 32'h0, 0, 0, 1);
        wr_group(8'h5C);
        pkt("R4 opcode 30 group match", 1, 1, 8'd30, 0, 16'h0, 8'h5C, 32'h0, 0, 0, 1);
        pkt("R4 opcode 30 group mismatch", 1, 1, 8'd30, 0, 16'h0, 8'h5D, 32'h0, 0, 0, 0);

        // R5
        pkt("R5 opcode 31 rejected", 1, 1, 8'd31, 0, 16'h0, 8'h5C, MY_TAG, 0, 0, 0);
        pkt("R5 opcode 0 rejected", 1, 1, 8'd0, 1, MY_OWN, 8'h5C, MY_TAG, 0, 0, 0);

        // R6
        pkt("R6 p2p tag match owner ignored", 1, 0, 8'h44, 1, 16'hDEAD, 8'h00, MY_TAG, 0, 0, 1);
        pkt("R6 p2p tag mismatch", 1, 0, 8'h44, 1, MY_OWN, 8'h5C, 32'h0, 0, 0, 0);

        // R7: decision held over a gap
        pkt("R7 accept after gap 5", 0, 0, 8'h05, 1, MY_OWN, 8'h00, MY_TAG, 5, 0, 1);
        pkt("R7 back-to-back accept", 1, 1, 8'd16, 0, 16'h0, 8'h00, 32'h0, 0, 0, 1);

        // R10: inputs scrambled and fields_valid repeated while held
        pkt("R10 held accept survives", 1, 1, 8'd35, 0, 16'h0, 8'h00, 32'h0, 4, 1, 1);
        pkt("R10 held reject survives", 0, 0, 8'h05, 1, MY_OWN, 8'h00, ~MY_TAG, 4, 1, 0);

        // R8: end-of-packet without any decision
        @(negedge clk); cur = "R8"; eop_i = 1;
        @(negedge clk); eop_i = 0;
        check("R8 eop before fields_valid", {wake_o, drop_o}, 2'b01);
        @(negedge clk);
        check("R8 pulse lasts one cycle", {wake_o, drop_o}, 2'b00);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule